// File: doc/BRIEF.md
# Circular Frame-Buffer Scan Address Generator

This block produces the sequence of video memory read addresses for one displayed frame. The frame buffer is a circular region, so a hardware scroll only moves the point where the scan begins. The scan starts at a scroll-dependent initial address and walks upward in bursts of a programmable transfer size. After the burst at the end address, it carries on from the wrap-start address (the buffer base).

Software writes the buffer base, buffer size, transfer size, burst count per frame and signed scroll steps into shadow registers through a small write port. The scroll arithmetic keeps the shadow start inside the buffer. Shadow values reach the running scan only at a vertical-sync pulse, so a frame in progress never sees a half-written configuration. A memory arbiter answers each burst request with a grant. The block pulses a frame-done flag once the programmed number of bursts has been granted.

Top module: `fbscan_addr_gen`

## Requirements
- R1: After reset, `burst_req`, `frame_done` and `burst_addr` are all 0.
- R2: In the cycle after a `vsync` pulse with a non-zero burst count, `burst_req` is 1 and `burst_addr` equals the shadow start address as it stood before that edge.
- R3: Configuration writes made while a frame is running do not change the addresses of that frame. They take effect at the next `vsync`.
- R4: Each cycle in which `burst_req` and `burst_gnt` are both 1 advances `burst_addr` by the transfer size. Without a grant, `burst_addr` holds.
- R5: The end address is base + size - transfer size. A granted burst at an address at or above the end address is followed by a burst at the base address.
- R6: Writing the base (select 0) sets the shadow start to the written base. A scroll write (select 3) adds the signed two's-complement data to the shadow start. A sum at or above base + size is reduced by the size, and a sum below base is raised by the size. The scroll step must be smaller than the size in magnitude.
- R7: After the grant of the last burst of a frame (count from select 4), `burst_req` falls and `frame_done` is 1 for exactly one cycle, the cycle after that grant.
- R8: A `vsync` while the burst count is 0 produces no request and no frame-done pulse.
- R9: A `vsync` during a running frame abandons it. The scan restarts at the new start address with a fresh burst count.
- R10: The select encoding is 0 base, 1 size, 2 transfer size, 3 scroll, 4 burst count. Writes with selects 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vsync | input | 1 | Vertical-sync pulse; commits shadow settings and starts a frame |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | AW (24) | Configuration write data |
| burst_gnt | input | 1 | Grant for the current burst request |
| burst_req | output | 1 | Burst request |
| burst_addr | output | AW (24) | Byte address of the requested burst |
| frame_done | output | 1 | One-cycle pulse after the last burst of a frame |

## Verification
The bench goes after the wrap boundary. A design that compared with the wrong bound would either read one burst past the buffer or wrap one burst early. It checks scroll steps that land exactly on base + size and steps that go below base; a design that got these wrong would start the frame outside the buffer. It makes configuration writes and a vsync in the middle of a frame, which catch a design that changes its live addresses without waiting for vsync or that keeps counting an abandoned frame. Burst counts of zero and one, and grants held back at random, expose an off-by-one in the frame-done pulse and addresses that move without a grant.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

    // Configuration register selects (software-visible encoding)
    typedef enum logic [2:0] {
        SEL_BASE   = 3'd0,
        SEL_SIZE   = 3'd1,
        SEL_XFER   = 3'd2,
        SEL_SCROLL = 3'd3,
        SEL_COUNT  = 3'd4
    } cfg_sel_e;

endpackage

// File: rtl/fbscan_shadow.sv
module fbscan_shadow
    import fbscan_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] sh_start,
    output logic [AW-1:0] sh_wrap,
    output logic [AW-1:0] sh_end,
    output logic [AW-1:0] sh_xfer,
    output logic [CW-1:0] sh_count
);

    localparam int SW = AW + 2;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] size;
        logic [AW-1:0] xfer;
        logic [AW-1:0] start;
        logic [CW-1:0] count;
    } shadow_t;

    shadow_t s_d, s_q;

    logic signed [SW-1:0] sum_w, base_w, lim_w, size_w, adj_w;

    // Scroll arithmetic: signed step, folded back into [base, base+size)
    always_comb begin
        base_w = $signed({2'b00, s_q.base});
        size_w = $signed({2'b00, s_q.size});
        lim_w  = base_w + size_w;
        sum_w  = $signed({2'b00, s_q.start}) + $signed({{2{cfg_wdata[AW-1]}}, cfg_wdata});
        if (sum_w >= lim_w) begin
            adj_w = sum_w - size_w;
        end else if (sum_w < base_w) begin
            adj_w = sum_w + size_w;
        end else begin
            adj_w = sum_w;
        end
    end

    always_comb begin
        s_d = s_q;
        if (cfg_we) begin
            case (cfg_sel)
                SEL_BASE: begin
                    s_d.base  = cfg_wdata;
                    s_d.start = cfg_wdata;
                end
                SEL_SIZE:   s_d.size  = cfg_wdata;
                SEL_XFER:   s_d.xfer  = cfg_wdata;
                SEL_SCROLL: s_d.start = adj_w[AW-1:0];
                SEL_COUNT:  s_d.count = cfg_wdata[CW-1:0];
                default:    s_d = s_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sh_start = s_q.start;
    assign sh_wrap  = s_q.base;
    assign sh_end   = s_q.base + s_q.size - s_q.xfer;
    assign sh_xfer  = s_q.xfer;
    assign sh_count = s_q.count;

    // R6: writing the base moves the start to it
    a_r6_base_sets_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_BASE) |=> (sh_start == $past(cfg_wdata)));

    // R6: a scroll from a start inside the buffer stays inside it
    a_r6_scroll_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_SCROLL && s_q.size != '0 &&
         s_q.start >= s_q.base &&
         {1'b0, s_q.start} < ({1'b0, s_q.base} + {1'b0, s_q.size}))
        |=> (sh_start >= sh_wrap &&
             {1'b0, sh_start} < ({1'b0, sh_wrap} + {1'b0, $past(s_q.size)})));

endmodule

// File: rtl/fbscan_walker.sv
module fbscan_walker #(
    parameter int AW = 24,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vsync,
    input  logic          gnt,
    input  logic [AW-1:0] sh_start,
    input  logic [AW-1:0] sh_wrap,
    input  logic [AW-1:0] sh_end,
    input  logic [AW-1:0] sh_xfer,
    input  logic [CW-1:0] sh_count,
    output logic          req,
    output logic [AW-1:0] addr,
    output logic          done
);

    typedef struct packed {
        logic [AW-1:0] wrap;
        logic [AW-1:0] stop;
        logic [AW-1:0] xfer;
        logic [CW-1:0] count;
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
    } walk_t;

    walk_t w_d, w_q;

    logic last_burst;

    assign last_burst = (w_q.cnt == w_q.count - 1'b1);

    always_comb begin
        w_d      = w_q;
        w_d.done = 1'b0;
        if (vsync) begin
            // commit shadow settings to the active copy and restart
            w_d.wrap  = sh_wrap;
            w_d.stop  = sh_end;
            w_d.xfer  = sh_xfer;
            w_d.count = sh_count;
            w_d.addr  = sh_start;
            w_d.cnt   = '0;
            w_d.busy  = (sh_count != '0);
        end else if (w_q.busy && gnt) begin
            w_d.cnt = w_q.cnt + 1'b1;
            if (last_burst) begin
                w_d.busy = 1'b0;
                w_d.done = 1'b1;
            end else if (w_q.addr >= w_q.stop) begin
                w_d.addr = w_q.wrap;
            end else begin
                w_d.addr = w_q.addr + w_q.xfer;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign req  = w_q.busy;
    assign addr = w_q.addr;
    assign done = w_q.done;

    // R2: a frame starts at the shadow start
    a_r2_vsync_load: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && sh_count != '0) |=> (req && addr == $past(sh_start)));

    // R4: no grant, no movement
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !gnt && !vsync) |=> (req && $stable(addr)));

    // R5: past the end, the scan resumes at the wrap-start address
    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (req && gnt && !vsync && addr >= w_q.stop && !last_burst)
        |=> (addr == $past(w_q.wrap)));

    // R7: frame-done is a single-cycle pulse with the request dropped
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req);

    // R8: an empty frame never requests
    a_r8_empty_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && sh_count == '0) |=> (!req && !done));

endmodule

// File: rtl/fbscan_addr_gen.sv
module fbscan_addr_gen #(
    parameter int AW = 24,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vsync,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          burst_gnt,
    output logic          burst_req,
    output logic [AW-1:0] burst_addr,
    output logic          frame_done
);

    logic [AW-1:0] sh_start, sh_wrap, sh_end, sh_xfer;
    logic [CW-1:0] sh_count;

    fbscan_shadow #(.AW(AW), .CW(CW)) i_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .sh_start  (sh_start),
        .sh_wrap   (sh_wrap),
        .sh_end    (sh_end),
        .sh_xfer   (sh_xfer),
        .sh_count  (sh_count)
    );

    fbscan_walker #(.AW(AW), .CW(CW)) i_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .vsync    (vsync),
        .gnt      (burst_gnt),
        .sh_start (sh_start),
        .sh_wrap  (sh_wrap),
        .sh_end   (sh_end),
        .sh_xfer  (sh_xfer),
        .sh_count (sh_count),
        .req      (burst_req),
        .addr     (burst_addr),
        .done     (frame_done)
    );

    // R1: quiet after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!burst_req && !frame_done));

endmodule

// File: tb/test_fbscan_addr_gen.sv
module test_fbscan_addr_gen;

    localparam int AW = 24;
    localparam int CW = 16;
    localparam longint AMASK = (64'd1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vsync = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          burst_gnt = 1'b0;
    logic          burst_req;
    logic [AW-1:0] burst_addr;
    logic          frame_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // shadow model
    longint m_base = 0, m_size = 0, m_xfer = 0, m_start = 0, m_n = 0;
    // active model
    longint e_wrap = 0, e_end = 0, e_xfer = 0, e_n = 0;

    always #5 clk = ~clk;

    fbscan_addr_gen #(.AW(AW), .CW(CW)) i_fbscan_addr_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .vsync      (vsync),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .burst_gnt  (burst_gnt),
        .burst_req  (burst_req),
        .burst_addr (burst_addr),
        .frame_done (frame_done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint f_scroll(longint start, longint delta);
        longint s;
        s = start + delta;
        if (s >= m_base + m_size) s = s - m_size;
        else if (s < m_base) s = s + m_size;
        return s;
    endfunction

    function automatic longint f_next(longint a);
        if (a >= e_end) return e_wrap;
        return (a + e_xfer) & AMASK;
    endfunction

    task automatic wr(input int sel, input longint data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = 3'(sel);
        cfg_wdata = AW'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: begin m_base = data; m_start = data; end
            1: m_size = data;
            2: m_xfer = data;
            3: m_start = f_scroll(m_start, data);
            4: m_n = data & ((64'd1 << CW) - 1);
            default: ;
        endcase
    endtask

    // stop_at >= 0 abandons the frame before burst stop_at
    task automatic run_frame(input int stop_at, input bit mid_write, input string t0);
        longint a;
        bit g;
        @(negedge clk);
        vsync = 1'b1;
        burst_gnt = 1'b0;
        @(negedge clk);
        vsync = 1'b0;
        e_wrap = m_base;
        e_end = (m_base + m_size - m_xfer) & AMASK;
        e_xfer = m_xfer;
        e_n = m_n;
        a = m_start;
        if (e_n == 0) begin
            chk(!burst_req && !frame_done, "R8", longint'(burst_req), 0);
            repeat (3) begin
                @(negedge clk);
                chk(!burst_req && !frame_done, "R8", longint'(frame_done), 0);
            end
            return;
        end
        for (int i = 0; i < e_n; i++) begin
            if (stop_at >= 0 && i == stop_at) begin
                burst_gnt = 1'b0;
                return;
            end
            if (mid_write && i == 1) begin
                burst_gnt = 1'b0;
                cfg_we = 1'b1;
                cfg_sel = 3'd3;
                cfg_wdata = AW'(m_xfer);
                @(negedge clk);
                cfg_we = 1'b0;
                m_start = f_scroll(m_start, m_xfer);
            end
            do begin
                chk(burst_req == 1'b1, (i == 0) ? t0 : "R4", longint'(burst_req), 1);
                chk(longint'(burst_addr) == a, (i == 0) ? t0 : (mid_write ? "R3" : "R5"),
                    longint'(burst_addr), a);
                g = ($urandom % 3) != 0;
                burst_gnt = g;
                @(negedge clk);
            end while (!g);
            a = f_next(a);
        end
        burst_gnt = 1'b0;
        chk(frame_done && !burst_req, "R7", longint'(frame_done), 1);
        @(negedge clk);
        chk(!frame_done, "R7", longint'(frame_done), 0);
    endtask

    initial begin
        #1ms;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(negedge clk);
        // R1
        chk(!burst_req && !frame_done && burst_addr == '0, "R1", longint'(burst_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!burst_req && !frame_done, "R1", longint'(burst_req), 0);

        // directed: basic frame, R2/R4
        wr(0, 'h1000); wr(1, 'h100); wr(2, 16); wr(4, 16);
        run_frame(-1, 0, "R2");
        // R6 below base, R5 wrap at end
        wr(3, -16);
        chk(m_start == 'h10F0, "R6", m_start, 'h10F0);
        run_frame(-1, 0, "R6");
        // R6 landing exactly on base+size
        wr(3, 16);
        run_frame(-1, 0, "R6");
        // R3 write during frame
        wr(3, 'h40);
        run_frame(-1, 1, "R3");
        run_frame(-1, 0, "R3");
        // R9 vsync mid-frame
        run_frame(5, 0, "R2");
        wr(3, 'h20);
        run_frame(-1, 0, "R9");
        // single burst
        wr(4, 1);
        run_frame(-1, 0, "R7");
        // empty frame
        wr(4, 0);
        run_frame(-1, 0, "R8");
        // R10 ignored selects
        wr(4, 8);
        wr(5, 'h777); wr(6, 'h55); wr(7, 'h1234);
        run_frame(-1, 0, "R10");
        // large transfer size
        wr(0, 'h20000); wr(2, 256); wr(1, 256 * 6); wr(4, 9); wr(3, 256 * 4);
        run_frame(-1, 0, "R5");

        // constrained random
        for (int it = 0; it < 14; it++) begin
            longint xf, nb, dl;
            xf = 64'd16 << ($urandom % 3);
            nb = 4 + ($urandom % 8);
            wr(0, longint'($urandom % 1024) * 64);
            wr(1, xf * nb);
            wr(2, xf);
            wr(4, 1 + ($urandom % (2 * nb)));
            dl = (longint'($urandom % (2 * nb - 1)) - (nb - 1)) * xf;
            wr(3, dl);
            run_frame(-1, 0, "R6");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule